// File: doc/BRIEF.md
# Packed Neuron Accumulate-and-Fire Unit

This unit keeps the membrane potentials of one bank of spiking neurons in an internal memory with a one-cycle read latency. Each 72-bit memory word holds two 36-bit signed potentials. The upper neuron sits in bits [71:36] and the lower neuron in bits [35:0]. A stream of 32-bit synapse words drives the unit. For each synapse word it reads the target word, picks the addressed half, and adds the sign-extended weight with saturation. It then compares the sum against a programmable signed threshold. Below the threshold, the sum is written back. At or above it, the neuron is cleared and a spike event carrying the neuron index is issued.

The unit accepts one synapse per clock while the spike consumer is ready. A pending write-back is forwarded to the next operation. Two consecutive synapses that hit the same word, even the two different halves of it, therefore see each other's results without any bubble. When a spike cannot be delivered, the pipeline freezes and the unit refuses new input until the event is taken.

Top module: `packed_fire_unit`

## Requirements
- R1: After reset every potential reads as zero, `spikeValid` is low and `synReady` is high.
- R2: A synapse word is decoded as opcode [31:29], target neuron [28:16] and weight [15:0]. Target bit 0 picks the half of the word (1 = upper, bits [71:36]), and target bits [12:1] pick the word.
- R3: The 16-bit weight is treated as two's complement and sign-extended to the potential width before it is added.
- R4: When the new potential is greater than or equal to `threshold` (both signed), the neuron's potential becomes 0. In the cycle after the synapse is accepted, `spikeValid` is high and `spikeNeuron` holds the 13-bit target.
- R5: When the new potential is below `threshold`, it is stored and no spike is issued.
- R6: An update leaves the other neuron of the same word unchanged.
- R7: A synapse with a nonzero opcode changes no potential and issues no spike.
- R8: The addition saturates at the most positive and most negative potential values instead of wrapping.
- R9: Back-to-back synapses to the same word, to the same or the other half, give the same results as if they were applied one at a time.
- R10: With `spikeReady` high, a synapse is accepted every cycle. While `spikeValid` is high and `spikeReady` is low, `synReady` is low, the spike is held unchanged, and no update happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| synValid | input | 1 | A synapse word is offered |
| synData | input | 32 | Synapse word: opcode, target, weight |
| synReady | output | 1 | Unit takes the offered synapse at this edge |
| threshold | input | 36 | Signed firing threshold |
| spikeValid | output | 1 | A spike event is presented |
| spikeNeuron | output | 13 | Index of the neuron that fired |
| spikeReady | input | 1 | Consumer takes the spike at this edge |

## Verification
The hardest case to reach from the ports is a synapse that reads a word whose previous update is still being written in the same cycle. It is driven by streaming ten synapses back to back with no idle cycles. Several of them alternate between the two halves of one word, so that every read depends on the forwarded value. Saturation cannot be reached with 16-bit weights against a 36-bit potential in a short run. A second instance with an 18-bit potential therefore drives both limits within a few adds, and the threshold is chosen so that a wrapped sum would fire when a saturated one would not, or the reverse. A stall is held for several cycles with a new synapse pending, so the test shows the spike stays put and the pending synapse is taken exactly once.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture the offered synapse and read its word
    logic advance;  // pipeline moves this edge
    logic write;    // commit the stage-1 result to memory
  } pfuStrobe_t;
endpackage

// File: rtl/pfu_ctrl.sv
module pfu_ctrl
  import pfu_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] inOpcode,
  output logic            inReady,
  input  logic            fire,
  output logic            spikeValid,
  input  logic            spikeReady,
  output pfuStrobe_t      strobe
);
  logic s1Valid;
  logic s1IsSyn;
  logic stall;

  assign spikeValid     = s1Valid && s1IsSyn && fire;
  assign stall          = spikeValid && !spikeReady;
  assign strobe.advance = !stall;
  assign strobe.load    = inValid && !stall;
  assign strobe.write   = s1Valid && s1IsSyn && !stall;
  assign inReady        = !stall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1IsSyn <= 1'b0;
    end else if (!stall) begin
      s1Valid <= inValid;
      s1IsSyn <= (inOpcode == '0);
    end
  end

  // R10
  spike_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spikeValid && !spikeReady) |=> spikeValid);

  // R10
  no_accept_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spikeValid && !spikeReady) |-> !inReady);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!spikeValid && inReady));
endmodule

// File: rtl/pfu_datapath.sv
module pfu_datapath
  import pfu_pkg::*;
#(
  parameter int NRN_W = 36,
  parameter int WT_W  = 16,
  parameter int TGT_W = 13,
  parameter int OP_W  = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pfuStrobe_t                    strobe,
  input  logic [OP_W+TGT_W+WT_W-1:0]    inData,
  input  logic [NRN_W-1:0]              threshold,
  output logic                          fire,
  output logic [TGT_W-1:0]              spikeAddr
);
  localparam int SYN_W  = OP_W + TGT_W + WT_W;
  localparam int TGT_LSB = WT_W;
  localparam int WORD_AW = TGT_W - 1;
  localparam int DEPTH   = 1 << WORD_AW;
  localparam int PAIR_W  = 2 * NRN_W;
  localparam logic [NRN_W-1:0] MAX_POT = {1'b0, {(NRN_W-1){1'b1}}};
  localparam logic [NRN_W-1:0] MIN_POT = {1'b1, {(NRN_W-1){1'b0}}};

  logic [TGT_W-1:0]   inTarget;
  logic [WORD_AW-1:0] inWord;
  assign inTarget = inData[TGT_LSB +: TGT_W];
  assign inWord   = inTarget[TGT_W-1:1];

  // stage-1 registers
  logic [TGT_W-1:0]   s1Target;
  logic [WT_W-1:0]    s1Weight;
  logic [WORD_AW-1:0] s1Word;
  logic               s1Upper;
  assign s1Word  = s1Target[TGT_W-1:1];
  assign s1Upper = s1Target[0];

  // storage
  logic [PAIR_W-1:0]  mem [DEPTH];
  logic [DEPTH-1:0]   written;
  logic [PAIR_W-1:0]  memQ;
  logic               memQVld;

  // forwarding register: the word committed at the edge stage 1 loaded
  logic               fwdVld;
  logic [WORD_AW-1:0] fwdWord;
  logic [PAIR_W-1:0]  fwdData;

  logic [PAIR_W-1:0]  base;
  logic [NRN_W-1:0]   curHalf;
  logic [NRN_W-1:0]   wExt;
  logic [NRN_W:0]     sumWide;
  logic [NRN_W-1:0]   satSum;
  logic [NRN_W-1:0]   newHalf;
  logic [PAIR_W-1:0]  newWord;

  always_comb begin
    if (fwdVld && fwdWord == s1Word) base = fwdData;
    else if (memQVld)                base = memQ;
    else                             base = '0;
    curHalf = s1Upper ? base[PAIR_W-1:NRN_W] : base[NRN_W-1:0];
    wExt    = {{(NRN_W-WT_W){s1Weight[WT_W-1]}}, s1Weight};
    sumWide = {curHalf[NRN_W-1], curHalf} + {wExt[NRN_W-1], wExt};
    if (!sumWide[NRN_W] && sumWide[NRN_W-1])      satSum = MAX_POT;
    else if (sumWide[NRN_W] && !sumWide[NRN_W-1]) satSum = MIN_POT;
    else                                          satSum = sumWide[NRN_W-1:0];
    fire    = $signed(satSum) >= $signed(threshold);
    newHalf = fire ? '0 : satSum;
    newWord = s1Upper ? {newHalf, base[NRN_W-1:0]}
                      : {base[PAIR_W-1:NRN_W], newHalf};
  end

  assign spikeAddr = s1Target;

  always_ff @(posedge clk) begin
    if (strobe.write) mem[s1Word] <= newWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      written  <= '0;
      memQ     <= '0;
      memQVld  <= 1'b0;
      s1Target <= '0;
      s1Weight <= '0;
      fwdVld   <= 1'b0;
      fwdWord  <= '0;
      fwdData  <= '0;
    end else begin
      if (strobe.write) written[s1Word] <= 1'b1;
      if (strobe.load) begin
        memQ     <= mem[inWord];
        memQVld  <= written[inWord];
        s1Target <= inTarget;
        s1Weight <= inData[WT_W-1:0];
      end
      if (strobe.advance) begin
        fwdVld  <= strobe.write;
        fwdWord <= s1Word;
        fwdData <= newWord;
      end
    end
  end

  // R6
  other_half_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |=> ($past(s1Upper)
      ? fwdData[NRN_W-1:0] == $past(base[NRN_W-1:0])
      : fwdData[PAIR_W-1:NRN_W] == $past(base[PAIR_W-1:NRN_W])));

  // R4
  fire_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && fire) |=> ($past(s1Upper)
      ? fwdData[PAIR_W-1:NRN_W] == '0 : fwdData[NRN_W-1:0] == '0));

  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> ($stable(s1Target) && $stable(s1Weight)));

  initial begin
    assert (NRN_W > WT_W && SYN_W <= 64)
      else $error("weight must be narrower than the potential");
  end
endmodule

// File: rtl/packed_fire_unit.sv
module packed_fire_unit
  import pfu_pkg::*;
#(
  parameter int NRN_W = 36,
  parameter int WT_W  = 16,
  parameter int TGT_W = 13,
  parameter int OP_W  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       synValid,
  input  logic [OP_W+TGT_W+WT_W-1:0] synData,
  output logic                       synReady,
  input  logic [NRN_W-1:0]           threshold,
  output logic                       spikeValid,
  output logic [TGT_W-1:0]           spikeNeuron,
  input  logic                       spikeReady
);
  localparam int OP_LSB = WT_W + TGT_W;

  pfuStrobe_t strobe;
  logic       fire;

  pfu_ctrl #(.OP_W(OP_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (synValid),
    .inOpcode  (synData[OP_LSB +: OP_W]),
    .inReady   (synReady),
    .fire      (fire),
    .spikeValid(spikeValid),
    .spikeReady(spikeReady),
    .strobe    (strobe)
  );

  pfu_datapath #(
    .NRN_W(NRN_W), .WT_W(WT_W), .TGT_W(TGT_W), .OP_W(OP_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (synData),
    .threshold (threshold),
    .fire      (fire),
    .spikeAddr (spikeNeuron)
  );
endmodule

// File: tb/test_packed_fire_unit.sv
module test_packed_fire_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // main instance (36-bit potentials)
  logic        synValid = 1'b0;
  logic [31:0] synData  = '0;
  logic        synReady;
  logic [35:0] threshold = 36'd1000;
  logic        spikeValid;
  logic [12:0] spikeNeuron;
  logic        spikeReady = 1'b1;

  packed_fire_unit i_packed_fire_unit (
    .clk(clk), .rstN(rstN), .synValid(synValid), .synData(synData),
    .synReady(synReady), .threshold(threshold), .spikeValid(spikeValid),
    .spikeNeuron(spikeNeuron), .spikeReady(spikeReady)
  );

  // narrow instance (18-bit potentials) to reach the saturation limits
  logic        sValid = 1'b0;
  logic [31:0] sData  = '0;
  logic        sReady;
  logic [17:0] sThr   = 18'd131071;
  logic        sSpkValid;
  logic [12:0] sSpkNeuron;

  packed_fire_unit #(.NRN_W(18)) i_sat (
    .clk(clk), .rstN(rstN), .synValid(sValid), .synData(sData),
    .synReady(sReady), .threshold(sThr), .spikeValid(sSpkValid),
    .spikeNeuron(sSpkNeuron), .spikeReady(1'b1)
  );

  // stream table: {opcode, target, weight}, expected spike, expected neuron
  localparam int NV = 10;
  localparam logic [31:0] VEC_SYN [NV] = '{
    {3'd0, 13'd4, 16'd600},   {3'd0, 13'd5, 16'd300},
    {3'd0, 13'd4, 16'd400},   {3'd0, 13'd5, 16'd700},
    {3'd0, 13'd4, 16'hFFFB},  {3'd1, 13'd4, 16'd2000},
    {3'd0, 13'd4, 16'd1005},  {3'd0, 13'd9, 16'd999},
    {3'd7, 13'd9, 16'd1},     {3'd0, 13'd9, 16'd1}
  };
  localparam bit VEC_SPK [NV] = '{0, 0, 1, 1, 0, 0, 1, 0, 0, 1};
  localparam logic [12:0] VEC_NRN [NV] = '{
    13'd0, 13'd0, 13'd4, 13'd5, 13'd0, 13'd0, 13'd4, 13'd0, 13'd0, 13'd9
  };
  localparam string VEC_REQ [NV] = '{
    "R5", "R6", "R9", "R9", "R3", "R7", "R7", "R2", "R7", "R4"
  };

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mainStep(input logic [31:0] syn, input bit expSpk,
                          input logic [12:0] expNrn, input string req);
    @(negedge clk);
    synValid = 1'b1;
    synData  = syn;
    @(negedge clk);
    synValid = 1'b0;
    chk(req, spikeValid, expSpk);
    if (expSpk) chk(req, spikeNeuron, expNrn);
  endtask

  task automatic satStep(input logic [31:0] syn, input bit expSpk,
                         input string req);
    @(negedge clk);
    sValid = 1'b1;
    sData  = syn;
    @(negedge clk);
    sValid = 1'b0;
    chk(req, sSpkValid, expSpk);
    if (expSpk) chk(req, sSpkNeuron, syn[28:16]);
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1", synReady, 1'b1);
    chk("R1", spikeValid, 1'b0);

    // R9/R10: streamed back to back, one synapse per cycle
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(VEC_REQ[i-1], spikeValid, VEC_SPK[i-1]);
        if (VEC_SPK[i-1]) chk(VEC_REQ[i-1], spikeNeuron, VEC_NRN[i-1]);
        chk("R10", synReady, 1'b1);
      end
      synValid = 1'b1;
      synData  = VEC_SYN[i];
    end
    @(negedge clk);
    synValid = 1'b0;
    chk(VEC_REQ[NV-1], spikeValid, VEC_SPK[NV-1]);
    chk(VEC_REQ[NV-1], spikeNeuron, VEC_NRN[NV-1]);

    // R8: positive saturation, threshold at the maximum
    for (int k = 0; k < 4; k++) satStep({3'd0, 13'd2, 16'd32767}, 1'b0, "R8");
    satStep({3'd0, 13'd2, 16'd32767}, 1'b1, "R8");
    // R8: negative saturation, threshold zero
    @(negedge clk);
    sThr = 18'd0;
    for (int k = 0; k < 5; k++) satStep({3'd0, 13'd3, 16'h8000}, 1'b0, "R8");
    for (int k = 0; k < 4; k++) satStep({3'd0, 13'd3, 16'd32767}, 1'b0, "R8");
    satStep({3'd0, 13'd3, 16'd4}, 1'b1, "R8");

    // R10: stall while the spike is not taken
    @(negedge clk);
    spikeReady = 1'b0;
    synValid   = 1'b1;
    synData    = {3'd0, 13'd20, 16'd1000};
    @(negedge clk);
    synData = {3'd0, 13'd21, 16'd5};
    for (int k = 0; k < 3; k++) begin
      chk("R10", spikeValid, 1'b1);
      chk("R10", spikeNeuron, 13'd20);
      chk("R10", synReady, 1'b0);
      @(negedge clk);
    end
    spikeReady = 1'b1;
    @(negedge clk);
    synValid = 1'b0;
    chk("R10", spikeValid, 1'b0);
    mainStep({3'd0, 13'd21, 16'd995}, 1'b1, 13'd21, "R10");

    // R1: reset clears stored potentials
    mainStep({3'd0, 13'd30, 16'd500}, 1'b0, 13'd0, "R5");
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk("R1", synReady, 1'b1);
    chk("R1", spikeValid, 1'b0);
    mainStep({3'd0, 13'd30, 16'd500}, 1'b0, 13'd0, "R1");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule